// File: doc/BRIEF.md
# Level Interrupt Aggregator with Two Routed Outputs

This block gathers 32 level-sensitive interrupt requests into two interrupt lines for a processor. Each request first passes through a two-stage synchronizer. The resulting levels are gated by an enable mask. A per-source route bit then decides which of the two lines the source feeds. Software sees the synchronized levels and the two gated and routed views through a small 32-bit register window.

The enable mask is never written directly. One address sets mask bits and another clears them, and only the 1 bits of the write data act. The top mask bit has two roles: it is the enable for source 31, and it is also the master switch for both interrupt lines. Pending bits are never latched, so a source that drops its request disappears from every view.

The register port is valid-only and never applies back-pressure. A request is taken on every clock edge where `req_valid` is high. Each read produces exactly one response, with `rsp_valid` high one cycle later. Writes produce no response.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mask and route registers read zero, both interrupt lines are low, and no response is pending.
- R2: Address 0x30 reads the source levels after two synchronizer flops, whatever the mask or route. A level change driven just before one clock edge is not yet visible to a read captured at the following edge.
- R3: A write to 0x34 sets each mask bit whose data bit is 1 and leaves the others unchanged. A read of 0x34 returns the mask.
- R4: A write to 0x38 clears each mask bit whose data bit is 1, and an all-ones write clears the whole mask including bit 31. A read of 0x38 returns zero.
- R5: Address 0x20 holds the route bits and reads back what was written. Route bit 0 steers a source to line 0 and route bit 1 steers it to line 1, so writing zero sends all sources to line 0.
- R6: Address 0x00 reads raw AND mask AND NOT route, and address 0x04 reads raw AND mask AND route. These views follow the levels and are never held.
- R7: `irq_o[n]` is high when mask bit 31 is set and pending view n is non-zero, one clock after the registers that feed it change.
- R8: While mask bit 31 is clear, both interrupt lines stay low whatever is pending.
- R9: A read is answered with `rsp_valid` high in the next cycle, using data captured at the request edge. Writes to 0x00, 0x04 and 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Asynchronous level requests, one bit per source |
| req_valid | input | 1 | Register request strobe, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 2 | Aggregated interrupt lines 0 and 1 |

## Verification
The bench uses the default parameters: 32 sources, a 32-bit data path and an 8-bit address. With 32 sources, bit 31 is both a source enable and the master gate, so an all-ones clear and a global-off state with non-zero pending views can both be produced and observed at the ports. The 8-bit address covers every register offset as well as the read-only offsets that writes must leave untouched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam logic [7:0] OFS_PEND0 = 8'h00;
  localparam logic [7:0] OFS_PEND1 = 8'h04;
  localparam logic [7:0] OFS_ROUTE = 8'h20;
  localparam logic [7:0] OFS_RAW   = 8'h30;
  localparam logic [7:0] OFS_SET   = 8'h34;
  localparam logic [7:0] OFS_CLR   = 8'h38;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND0,
    SEL_PEND1,
    SEL_ROUTE,
    SEL_RAW,
    SEL_SET,
    SEL_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    case (a)
      OFS_PEND0: decode_addr = SEL_PEND0;
      OFS_PEND1: decode_addr = SEL_PEND1;
      OFS_ROUTE: decode_addr = SEL_ROUTE;
      OFS_RAW:   decode_addr = SEL_RAW;
      OFS_SET:   decode_addr = SEL_SET;
      OFS_CLR:   decode_addr = SEL_CLR;
      default:   decode_addr = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_i[b];
        stable_q <= meta_q;
      end
    end
    assign sync_o[b] = stable_q;
  end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [NUM_SRC-1:0] req_wdata,
  input  logic [NUM_SRC-1:0] raw,
  input  logic [NUM_SRC-1:0] pend0,
  input  logic [NUM_SRC-1:0] pend1,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] route_q,
  output logic               rsp_valid,
  output logic [NUM_SRC-1:0] rsp_rdata
);

  localparam int GLB_BIT = NUM_SRC - 1;

  reg_sel_e sel;
  logic     do_wr;
  logic     do_rd;
  logic [NUM_SRC-1:0] rd_mux;

  assign sel   = decode_addr(8'(req_addr));
  assign do_wr = req_valid && req_write;
  assign do_rd = req_valid && !req_write;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[b] <= 1'b0;
      end else if (do_wr && req_wdata[b]) begin
        if (sel == SEL_SET) mask_q[b] <= 1'b1;
        else if (sel == SEL_CLR) mask_q[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= '0;
    else if (do_wr && sel == SEL_ROUTE) route_q <= req_wdata;
  end

  always_comb begin
    case (sel)
      SEL_PEND0: rd_mux = pend0;
      SEL_PEND1: rd_mux = pend1;
      SEL_ROUTE: rd_mux = route_q;
      SEL_RAW:   rd_mux = raw;
      SEL_SET:   rd_mux = mask_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= do_rd;
      if (do_rd) rsp_rdata <= rd_mux;
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |=> rsp_valid); // R9

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && req_addr == ADDR_W'(OFS_SET)) |=>
      ((mask_q & $past(req_wdata)) == $past(req_wdata))); // R3

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && req_addr == ADDR_W'(OFS_CLR) && &req_wdata) |=>
      (mask_q == '0 && !mask_q[GLB_BIT])); // R4

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && req_addr == ADDR_W'(OFS_CLR)) |=> (rsp_rdata == '0)); // R4

endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_SRC = 32,
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raw,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] route_q,
  output logic [NUM_SRC-1:0] pend0,
  output logic [NUM_SRC-1:0] pend1,
  output logic [NUM_OUT-1:0] irq_o
);

  localparam int GLB_BIT = NUM_SRC - 1;

  logic [NUM_SRC-1:0] live;
  logic [NUM_OUT-1:0] fire;

  assign live  = raw & mask_q;
  assign pend0 = live & ~route_q;
  assign pend1 = live & route_q;

  assign fire[0] = mask_q[GLB_BIT] && (|pend0);
  assign fire[1] = mask_q[GLB_BIT] && (|pend1);

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o[n] <= 1'b0;
      else        irq_o[n] <= fire[n];
    end
  end

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[GLB_BIT] |=> (irq_o == '0)); // R8

  AST_LINE0_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> $past(|(raw & mask_q & ~route_q))); // R7

  AST_LINE1_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[1]) |-> $past(|(raw & mask_q & route_q))); // R7

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [NUM_SRC-1:0] req_wdata,
  output logic               rsp_valid,
  output logic [NUM_SRC-1:0] rsp_rdata,
  output logic [1:0]         irq_o
);

  localparam int NUM_OUT = 2;

  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] route_q;
  logic [NUM_SRC-1:0] pend0;
  logic [NUM_SRC-1:0] pend1;

  irq_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .sync_o  (raw)
  );

  irq_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .raw       (raw),
    .pend0     (pend0),
    .pend1     (pend1),
    .mask_q    (mask_q),
    .route_q   (route_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  irq_route #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (raw),
    .mask_q  (mask_q),
    .route_q (route_q),
    .pend0   (pend0),
    .pend1   (pend1),
    .irq_o   (irq_o)
  );

endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", {30'b0, irq_o}, 32'd0);
    chk("R1 no response", {31'b0, rsp_valid}, 32'd0);
    rd(8'h34, d); chk("R1 mask", d, 32'd0);
    rd(8'h20, d); chk("R1 route", d, 32'd0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    src_i = 32'hA5A5_0F0F;
    settle();
    rd(8'h30, d); chk("R2 raw ignores mask", d, 32'hA5A5_0F0F);
    chk("R7 no line with mask zero", {30'b0, irq_o}, 32'd0);
    @(negedge clk);
    src_i = 32'h0000_1234;
    rd(8'h30, d); chk("R2 two-stage latency old", d, 32'hA5A5_0F0F);
    rd(8'h30, d); chk("R2 new level", d, 32'h0000_1234);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h34, 32'h0000_00F0);
    rd(8'h34, d); chk("R3 set", d, 32'h0000_00F0);
    wr(8'h34, 32'h0000_0300);
    rd(8'h34, d); chk("R3 zero bits keep", d, 32'h0000_03F0);
    wr(8'h38, 32'h0000_0010);
    rd(8'h34, d); chk("R4 clear one bit", d, 32'h0000_03E0);
    rd(8'h38, d); chk("R4 clear reads zero", d, 32'd0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    src_i = 32'h0000_0FFF;
    wr(8'h20, 32'h0000_0200);
    settle();
    rd(8'h20, d); chk("R5 route readback", d, 32'h0000_0200);
    rd(8'h00, d); chk("R6 pending0", d, 32'h0000_01E0);
    rd(8'h04, d); chk("R6 pending1", d, 32'h0000_0200);
    chk("R8 global off", {30'b0, irq_o}, 32'd0);
    wr(8'h34, 32'h8000_0000);
    chk("R7 one cycle latency", {30'b0, irq_o}, 32'd0);
    @(negedge clk);
    chk("R7 both lines", {30'b0, irq_o}, 32'd3);
    src_i = 32'h0000_0DFF;
    settle();
    chk("R6 line1 drops", {30'b0, irq_o}, 32'd1);
    rd(8'h04, d); chk("R6 pending1 not held", d, 32'd0);
    src_i = 32'd0;
    settle();
    chk("R7 all quiet", {30'b0, irq_o}, 32'd0);
    rd(8'h00, d); chk("R6 pending0 empty", d, 32'd0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h34, d); chk("R9 mask untouched", d, 32'h8000_03E0);
    rd(8'h20, d); chk("R9 route untouched", d, 32'h0000_0200);
  endtask

  task automatic t_all_to_zero();
    logic [31:0] d;
    wr(8'h20, 32'd0);
    wr(8'h34, 32'hFFFF_FFFF);
    src_i = 32'hFFFF_FFFF;
    settle();
    rd(8'h00, d); chk("R5 all to line0", d, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R5 line1 empty", d, 32'd0);
    chk("R5 only line0", {30'b0, irq_o}, 32'd1);
  endtask

  task automatic t_clear_all();
    logic [31:0] d;
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h34, d); chk("R4 clear all incl global", d, 32'd0);
    settle();
    chk("R8 lines low", {30'b0, irq_o}, 32'd0);
    wr(8'h34, 32'h0000_00FF);
    settle();
    chk("R8 pending but global off", {30'b0, irq_o}, 32'd0);
    rd(8'h00, d); chk("R8 pending visible", d, 32'h0000_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_mask();
    t_route();
    t_readonly();
    t_all_to_zero();
    t_clear_all();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule